// File: doc/BRIEF.md
# Data Breakpoint and Address Remap Unit

This unit sits on the load/store address path of a small 32-bit core and treats every data access in three ways. It first relocates low addresses into a per-process window: a 7-bit process identifier occupies the top seven address bits, and it is merged into any address whose top seven bits are all clear. It then checks the low two address bits against word alignment when alignment checking is enabled. Finally, it compares the relocated address against two programmable data watchpoints. Each watchpoint can be armed for loads, for stores, or for both.

Software configures the unit through a single write port that selects one of five registers: process identifier, control, watch value 0, watch value 1, and watch control. The two watchpoints either act independently on word addresses, or fuse into one value/mask pair in which watch value 1 supplies don't-care bits. All results are registered. The relocated address, the alignment-abort pulse, the watch-hit pulse and the entry-reason code appear one clock after the access is presented. The unit has no state machine. Its only state is the configuration registers and the output stage.

Top module: `dbrk_unit`

## Requirements
- R1: While reset is asserted and after it is released, every output is zero and every configuration register is zero. With zero registers, both watchpoints are disabled, alignment checking is off and addresses pass through unchanged.
- R2: When the process identifier (held in bits 31:25 of the value written with select 0) is nonzero and bits 31:25 of the access address are all zero, the output address is the access address with the identifier placed in bits 31:25.
- R3: When the identifier is zero, or any of address bits 31:25 is set, the output address equals the access address.
- R4: When alignment checking is enabled (bit 1 of the value written with select 1) and a valid access has either of address bits 1:0 set, the unit raises the alignment-abort output for one cycle.
- R5: With alignment checking disabled, a misaligned access raises no alignment abort.
- R6: Each watchpoint has a 2-bit direction mode. Watchpoint 0 takes it from watch-control (select 4) bits 1:0 and watchpoint 1 from bits 3:2. The codes are 0 disabled, 1 stores only, 2 loads and stores, 3 loads only. A store is flagged by the store input being 1.
- R7: In independent mode (watch-control bit 8 clear), watchpoint k (value written with select 2+k) hits when address bits 31:2 equal its value bits 31:2 and its direction mode permits the access. Address bits 1:0 are ignored.
- R8: In fused mode (watch-control bit 8 set), set bits of watch value 1 are don't-care. The access hits when all 32 remaining bits equal watch value 0 and watchpoint 0's direction mode permits the access. Watchpoint 1's own comparison is ignored.
- R9: The entry-reason output is 2 in the cycle the watch-hit output is high, and 0 otherwise.
- R10: Watchpoint comparison uses the address after process-identifier relocation.
- R11: With the access-valid input low, neither the alignment-abort output nor the watch-hit output rises, whatever the address.
- R12: If both watchpoints hit on the same access, the unit reports one single-cycle hit.
- R13: A register write takes effect from the cycle after it. An access presented in the same cycle as the write is judged against the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access address |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | Register select (0 id, 1 control, 2 value 0, 3 value 1, 4 watch control) |
| cfg_wdata | input | 32 | Register write data |
| phys_addr | output | 32 | Relocated address, one cycle after the access |
| align_abort | output | 1 | Alignment-abort pulse |
| brk_hit | output | 1 | Watchpoint-hit pulse |
| brk_reason | output | 3 | Entry-reason code, 2 on a data watch hit |

## Verification
Relocation is tried with addresses whose top seven bits are clear, with addresses whose top bit or lowest identifier bit is set, and with a zero identifier. These cases separate the merge from a blind OR and from unconditional passthrough. Each direction code is paired with both a load and a store, which shows whether the mode decoding or the store sense is inverted. Addresses that differ from a watch value only in bits 1:0 tell the word compare of independent mode apart from the full-width masked compare of fused mode. A fused-mode case whose address matches watch value 1 as an address shows that watchpoint 1 is really disconnected.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;

    localparam int unsigned DBRK_AW     = 32;
    localparam int unsigned DBRK_PID_W  = 7;
    localparam int unsigned DBRK_ALIGN  = 2;
    localparam int unsigned DBRK_NCMP   = 2;

    localparam int unsigned CTL_ALIGN_BIT = 1;
    localparam int unsigned WC_M0_LSB     = 0;
    localparam int unsigned WC_M1_LSB     = 2;
    localparam int unsigned WC_FUSE_BIT   = 8;

    localparam logic [2:0] REASON_DATA = 3'd2;

    typedef enum logic [1:0] {
        DIR_OFF   = 2'd0,
        DIR_STORE = 2'd1,
        DIR_BOTH  = 2'd2,
        DIR_LOAD  = 2'd3
    } dir_mode_e;

    typedef enum logic [2:0] {
        SEL_PID   = 3'd0,
        SEL_CTL   = 3'd1,
        SEL_VAL0  = 3'd2,
        SEL_VAL1  = 3'd3,
        SEL_WCTL  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/dbrk_cfg_regs.sv
module dbrk_cfg_regs
    import dbrk_pkg::*;
#(
    parameter int unsigned ADDR_W = DBRK_AW,
    parameter int unsigned PID_W  = DBRK_PID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [PID_W-1:0]  pid,
    output logic              align_en,
    output logic              fuse_mode,
    output logic [1:0]        mode0,
    output logic [1:0]        mode1,
    output logic [ADDR_W-1:0] val0,
    output logic [ADDR_W-1:0] val1
);

    localparam int unsigned PID_LSB = ADDR_W - PID_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid       <= '0;
            align_en  <= 1'b0;
            fuse_mode <= 1'b0;
            mode0     <= DIR_OFF;
            mode1     <= DIR_OFF;
            val0      <= '0;
            val1      <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_PID:  pid      <= wr_data[ADDR_W-1:PID_LSB];
                SEL_CTL:  align_en <= wr_data[CTL_ALIGN_BIT];
                SEL_VAL0: val0     <= wr_data;
                SEL_VAL1: val1     <= wr_data;
                SEL_WCTL: begin
                    mode0     <= wr_data[WC_M0_LSB +: 2];
                    mode1     <= wr_data[WC_M1_LSB +: 2];
                    fuse_mode <= wr_data[WC_FUSE_BIT];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dbrk_remap.sv
module dbrk_remap
    import dbrk_pkg::*;
#(
    parameter int unsigned ADDR_W  = DBRK_AW,
    parameter int unsigned PID_W   = DBRK_PID_W,
    parameter int unsigned ALIGN_W = DBRK_ALIGN
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [PID_W-1:0]  pid,
    input  logic              align_en,
    output logic [ADDR_W-1:0] addr_out,
    output logic              misaligned
);

    localparam int unsigned PID_LSB = ADDR_W - PID_W;

    logic top_clear;
    logic pid_set;

    always_comb begin
        top_clear  = ~|addr_in[ADDR_W-1:PID_LSB];
        pid_set    = |pid;
        addr_out   = addr_in;
        if (pid_set && top_clear) begin
            addr_out[ADDR_W-1:PID_LSB] = pid;
        end
        misaligned = align_en && (|addr_in[ALIGN_W-1:0]);
    end

endmodule

// File: rtl/dbrk_cmp.sv
module dbrk_cmp
    import dbrk_pkg::*;
#(
    parameter int unsigned ADDR_W  = DBRK_AW,
    parameter int unsigned ALIGN_W = DBRK_ALIGN
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_store,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] value,
    input  logic              use_mask,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);

    logic dir_ok;
    logic addr_eq;

    always_comb begin
        unique case (dir_mode_e'(mode))
            DIR_OFF:   dir_ok = 1'b0;
            DIR_STORE: dir_ok = is_store;
            DIR_BOTH:  dir_ok = 1'b1;
            DIR_LOAD:  dir_ok = !is_store;
            default:   dir_ok = 1'b0;
        endcase

        if (use_mask) begin
            addr_eq = ~|((addr ^ value) & ~mask);
        end else begin
            addr_eq = (addr[ADDR_W-1:ALIGN_W] == value[ADDR_W-1:ALIGN_W]);
        end

        hit = dir_ok && addr_eq;
    end

endmodule

// File: rtl/dbrk_unit.sv
module dbrk_unit
    import dbrk_pkg::*;
#(
    parameter int unsigned ADDR_W  = DBRK_AW,
    parameter int unsigned PID_W   = DBRK_PID_W,
    parameter int unsigned ALIGN_W = DBRK_ALIGN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              align_abort,
    output logic              brk_hit,
    output logic [2:0]        brk_reason
);

    localparam int unsigned NCMP = DBRK_NCMP;

    logic [PID_W-1:0]  pid;
    logic              align_en;
    logic              fuse_mode;
    logic [1:0]        mode0;
    logic [1:0]        mode1;
    logic [ADDR_W-1:0] val0;
    logic [ADDR_W-1:0] val1;

    logic [ADDR_W-1:0] reloc_addr;
    logic              misaligned;

    logic [ADDR_W-1:0] cmp_val  [NCMP];
    logic [1:0]        cmp_mode [NCMP];
    logic [NCMP-1:0]   raw_hit;
    logic [NCMP-1:0]   eff_hit;
    logic              any_hit;

    dbrk_cfg_regs #(
        .ADDR_W (ADDR_W),
        .PID_W  (PID_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .pid       (pid),
        .align_en  (align_en),
        .fuse_mode (fuse_mode),
        .mode0     (mode0),
        .mode1     (mode1),
        .val0      (val0),
        .val1      (val1)
    );

    dbrk_remap #(
        .ADDR_W  (ADDR_W),
        .PID_W   (PID_W),
        .ALIGN_W (ALIGN_W)
    ) u_remap (
        .addr_in    (acc_addr),
        .pid        (pid),
        .align_en   (align_en),
        .addr_out   (reloc_addr),
        .misaligned (misaligned)
    );

    assign cmp_val[0]  = val0;
    assign cmp_val[1]  = val1;
    assign cmp_mode[0] = mode0;
    assign cmp_mode[1] = mode1;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        if (i == 0) begin : g_primary
            dbrk_cmp #(
                .ADDR_W  (ADDR_W),
                .ALIGN_W (ALIGN_W)
            ) u_cmp (
                .addr     (reloc_addr),
                .is_store (acc_store),
                .mode     (cmp_mode[i]),
                .value    (cmp_val[i]),
                .use_mask (fuse_mode),
                .mask     (val1),
                .hit      (raw_hit[i])
            );
            assign eff_hit[i] = raw_hit[i];
        end else begin : g_secondary
            dbrk_cmp #(
                .ADDR_W  (ADDR_W),
                .ALIGN_W (ALIGN_W)
            ) u_cmp (
                .addr     (reloc_addr),
                .is_store (acc_store),
                .mode     (cmp_mode[i]),
                .value    (cmp_val[i]),
                .use_mask (1'b0),
                .mask     ('0),
                .hit      (raw_hit[i])
            );
            assign eff_hit[i] = raw_hit[i] && !fuse_mode;
        end
    end

    assign any_hit = |eff_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phys_addr   <= '0;
            align_abort <= 1'b0;
            brk_hit     <= 1'b0;
            brk_reason  <= '0;
        end else begin
            phys_addr   <= reloc_addr;
            align_abort <= acc_valid && misaligned;
            brk_hit     <= acc_valid && any_hit;
            brk_reason  <= (acc_valid && any_hit) ? REASON_DATA : 3'd0;
        end
    end

    a_r11_events_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (align_abort || brk_hit) |-> $past(acc_valid));

    a_r9_reason_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |-> (brk_reason == REASON_DATA));

    a_r9_reason_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_hit |-> (brk_reason == 3'd0));

    a_r5_abort_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        align_abort |-> $past(align_en));

    a_r3_zero_pid_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pid) == '0) |-> (phys_addr == $past(acc_addr)));

    a_r8_fused_needs_cmp0: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_hit && $past(fuse_mode)) |-> ($past(mode0) != 2'd0));

endmodule

// File: tb/dbrk_unit_bench.sv
module dbrk_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    typedef struct packed {
        logic [31:0] pid;
        logic [31:0] ctl;
        logic [31:0] wctl;
        logic [31:0] v0;
        logic [31:0] v1;
        logic        st;
        logic [31:0] addr;
        logic [31:0] exp_addr;
        logic        exp_abort;
        logic        exp_hit;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        // R2 relocation into identifier window
        '{32'h0A000000, 0, 0, 0, 0, 1'b0, 32'h00001234, 32'h0A001234, 1'b0, 1'b0, 8'd2},
        // R3 top bits already set
        '{32'h0A000000, 0, 0, 0, 0, 1'b0, 32'h02001000, 32'h02001000, 1'b0, 1'b0, 8'd3},
        '{32'h0A000000, 0, 0, 0, 0, 1'b1, 32'h80000010, 32'h80000010, 1'b0, 1'b0, 8'd3},
        // R3 zero identifier
        '{32'h00000000, 0, 0, 0, 0, 1'b0, 32'h00000040, 32'h00000040, 1'b0, 1'b0, 8'd3},
        // R4 alignment checking on
        '{0, 32'h2, 0, 0, 0, 1'b0, 32'h00001001, 32'h00001001, 1'b1, 1'b0, 8'd4},
        '{0, 32'h2, 0, 0, 0, 1'b1, 32'h00001002, 32'h00001002, 1'b1, 1'b0, 8'd4},
        '{0, 32'h2, 0, 0, 0, 1'b0, 32'h00001000, 32'h00001000, 1'b0, 1'b0, 8'd4},
        // R5 alignment checking off
        '{0, 0, 0, 0, 0, 1'b1, 32'h00001003, 32'h00001003, 1'b0, 1'b0, 8'd5},
        // R6 direction modes
        '{0, 0, 32'h1, 32'h2000, 0, 1'b1, 32'h2000, 32'h2000, 1'b0, 1'b1, 8'd6},
        '{0, 0, 32'h1, 32'h2000, 0, 1'b0, 32'h2000, 32'h2000, 1'b0, 1'b0, 8'd6},
        '{0, 0, 32'h3, 32'h2000, 0, 1'b0, 32'h2000, 32'h2000, 1'b0, 1'b1, 8'd6},
        '{0, 0, 32'h3, 32'h2000, 0, 1'b1, 32'h2000, 32'h2000, 1'b0, 1'b0, 8'd6},
        // R7 word compare ignores bits 1:0
        '{0, 0, 32'h2, 32'h2000, 0, 1'b1, 32'h2003, 32'h2003, 1'b0, 1'b1, 8'd7},
        '{0, 0, 32'h2, 32'h2000, 0, 1'b0, 32'h2004, 32'h2004, 1'b0, 1'b0, 8'd7},
        // R7 watchpoint 1 alone
        '{0, 0, 32'h8, 0, 32'h3000, 1'b0, 32'h3000, 32'h3000, 1'b0, 1'b1, 8'd7},
        // R6 watchpoint 1 stores only, load given
        '{0, 0, 32'h4, 0, 32'h3000, 1'b0, 32'h3000, 32'h3000, 1'b0, 1'b0, 8'd6},
        // R8 fused value/mask
        '{0, 0, 32'h102, 32'h4000, 32'hFF0, 1'b0, 32'h4AB0, 32'h4AB0, 1'b0, 1'b1, 8'd8},
        '{0, 0, 32'h102, 32'h4000, 32'hFF0, 1'b1, 32'h5000, 32'h5000, 1'b0, 1'b0, 8'd8},
        '{0, 0, 32'h102, 32'h4000, 32'hFF0, 1'b0, 32'h4001, 32'h4001, 1'b0, 1'b0, 8'd8},
        '{0, 0, 32'h10E, 32'h4000, 32'hFF0, 1'b0, 32'h0FF0, 32'h0FF0, 1'b0, 1'b0, 8'd8},
        // R10 compare after relocation
        '{32'h0A000000, 0, 32'h2, 32'h0A002000, 0, 1'b0, 32'h2000, 32'h0A002000, 1'b0, 1'b1, 8'd10},
        // R12 both watchpoints hit
        '{0, 0, 32'hA, 32'h6000, 32'h6000, 1'b0, 32'h6000, 32'h6000, 1'b0, 1'b1, 8'd12},
        // R6 disabled mode
        '{0, 0, 32'h0, 32'h2000, 0, 1'b1, 32'h2000, 32'h2000, 1'b0, 1'b0, 8'd6}
    };

    logic        clk;
    logic        rst_n;
    logic        acc_valid;
    logic        acc_store;
    logic [31:0] acc_addr;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] phys_addr;
    logic        align_abort;
    logic        brk_hit;
    logic [2:0]  brk_reason;

    int total;
    int bad;

    dbrk_unit u_dbrk_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_store   (acc_store),
        .acc_addr    (acc_addr),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .phys_addr   (phys_addr),
        .align_abort (align_abort),
        .brk_hit     (brk_hit),
        .brk_reason  (brk_reason)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic access(input logic st, input logic [31:0] addr);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_store = st;
        acc_addr  = addr;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        string tag;
        total     = 0;
        bad       = 0;
        rst_n     = 1'b0;
        acc_valid = 1'b0;
        acc_store = 1'b0;
        acc_addr  = '0;
        cfg_we    = 1'b0;
        cfg_sel   = '0;
        cfg_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        chk("R1 addr in reset", phys_addr, 32'h0);
        chk("R1 abort in reset", {31'd0, align_abort}, 32'h0);
        chk("R1 hit in reset", {31'd0, brk_hit}, 32'h0);
        rst_n = 1'b1;
        // R1 registers cleared: misaligned word-zero access, no effect
        access(1'b1, 32'h00000003);
        chk("R1 addr after reset", phys_addr, 32'h00000003);
        chk("R1 abort after reset", {31'd0, align_abort}, 32'h0);
        chk("R1 hit after reset", {31'd0, brk_hit}, 32'h0);
        chk("R1 reason after reset", {29'd0, brk_reason}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            wr(3'd0, VEC[i].pid);
            wr(3'd1, VEC[i].ctl);
            wr(3'd2, VEC[i].v0);
            wr(3'd3, VEC[i].v1);
            wr(3'd4, VEC[i].wctl);
            access(VEC[i].st, VEC[i].addr);
            chk({tag, " addr"}, phys_addr, VEC[i].exp_addr);
            chk({tag, " abort"}, {31'd0, align_abort}, {31'd0, VEC[i].exp_abort});
            chk({tag, " hit"}, {31'd0, brk_hit}, {31'd0, VEC[i].exp_hit});
            // R9 reason code follows hit
            chk({tag, " R9 reason"}, {29'd0, brk_reason}, VEC[i].exp_hit ? 32'd2 : 32'd0);
            if (VEC[i].req == 8'd12) begin
                // R12 single pulse: next idle cycle is clear
                @(negedge clk);
                chk("R12 single pulse", {31'd0, brk_hit}, 32'h0);
            end
        end

        // R11 strobe low: no events though address would hit and is misaligned
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h2);
        wr(3'd2, 32'h8000);
        wr(3'd4, 32'h2);
        @(negedge clk);
        acc_valid = 1'b0;
        acc_store = 1'b0;
        acc_addr  = 32'h8001;
        @(negedge clk);
        chk("R11 no abort without valid", {31'd0, align_abort}, 32'h0);
        chk("R11 no hit without valid", {31'd0, brk_hit}, 32'h0);
        chk("R11 addr still flows", phys_addr, 32'h8001);

        // R13 write and access in the same cycle
        wr(3'd1, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd2, 32'h7000);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 3'd4;
        cfg_wdata = 32'h2;
        acc_valid = 1'b1;
        acc_store = 1'b0;
        acc_addr  = 32'h7000;
        @(negedge clk);
        cfg_we    = 1'b0;
        acc_valid = 1'b0;
        chk("R13 same-cycle write uses old setting", {31'd0, brk_hit}, 32'h0);
        access(1'b0, 32'h7000);
        chk("R13 write effective next cycle", {31'd0, brk_hit}, 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule